// File: doc/BRIEF.md
# Per-Port Rounding and Masking Output Formatter

This block formats four 12-bit output lanes (A, B, C, D) for a mixer datapath. Each lane picks one of two candidate words. One is a mixer result: the even or odd I or Q sample. The other is the matching symbol or oscillator sample: symbol I, symbol Q, cosine or sine. The lane then rounds the chosen word to 12, 10 or 8 significant bits, clears bits through its own 12-bit AND mask, and drives the result only while that lane is enabled.

All words are two's-complement. Rounding adds half of the least significant kept bit and then clears the dropped bits. A positive overflow clamps to the largest positive value that can be represented at the chosen width; it does not wrap. The mask is applied after rounding. A lane that is switched off drives zero and lowers its enable flag.

Each lane's data and flag are registered, so a change at the inputs appears one clock later. The configuration inputs are static fields that a register bank elsewhere drives.

Top module: `out_formatter`

## Requirements
- R1: During and right after synchronous active-low reset, all four lanes drive 12'h000 and every bit of `lane_oe` is 0.
- R2: With `src_sel[k]`=0, the lanes carry the mixer words: lane A carries `mix_i_even`, lane B `mix_q_even`, lane C `mix_i_odd` and lane D `mix_q_odd`.
- R3: With `src_sel[k]`=1, the lanes carry the snapshot words: lane A carries `snap_si`, lane B `snap_sq`, lane C `nco_cos` and lane D `nco_sin`.
- R4: Round code 0 or 3 in `rnd_mode[2k+1:2k]` passes the selected word through with all 12 bits unchanged.
- R5: Round code 1 keeps 10 bits. It adds 2 to the word and clears bits [1:0].
- R6: Round code 2 keeps 8 bits. It adds 8 to the word and clears bits [3:0].
- R7: A rounding carry that goes past the largest positive value clamps. The result is 12'h7FC for code 1 and 12'h7F0 for code 2.
- R8: The rounded word is ANDed with `mask_word[12k+11:12k]`, so every 0 bit of the mask clears the matching output bit.
- R9: When `lane_en[k]`=0, lane k drives 12'h000 and `lane_oe[k]` is 0. When `lane_en[k]`=1, `lane_oe[k]` is 1.
- R10: Results appear exactly one clock after the inputs are applied. Each lane's select, round, mask and enable fields act on that lane only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mix_i_even | input | 12 | Mixer I, even sample |
| mix_q_even | input | 12 | Mixer Q, even sample |
| mix_i_odd | input | 12 | Mixer I, odd sample |
| mix_q_odd | input | 12 | Mixer Q, odd sample |
| snap_si | input | 12 | Symbol I sample |
| snap_sq | input | 12 | Symbol Q sample |
| nco_cos | input | 12 | Oscillator cosine sample |
| nco_sin | input | 12 | Oscillator sine sample |
| src_sel | input | 4 | Per-lane source select, bit k for lane k (A=0) |
| rnd_mode | input | 8 | Per-lane round code, bits [2k+1:2k] |
| mask_word | input | 48 | Per-lane AND mask, bits [12k+11:12k] |
| lane_en | input | 4 | Per-lane output enable |
| lane_a | output | 12 | Formatted lane A |
| lane_b | output | 12 | Formatted lane B |
| lane_c | output | 12 | Formatted lane C |
| lane_d | output | 12 | Formatted lane D |
| lane_oe | output | 4 | Registered per-lane enable flags |

## Verification
The block holds one register per lane and no other state. A wrong value in that register shows at the lane output in the cycle right after the stimulus, and is overwritten on the following clock. A broken source mux or lane index shows as the word of another lane appearing at the output. Errors in the round carry or the clamp only show up for particular values: words whose dropped bits are at least half an LSB, words next to the positive limit, and negative words. For that reason the stimulus covers each of these ranges together with masks that are not all ones.

// File: rtl/fmt_pkg.sv
// Package: shared widths and round-code encoding for the output formatter.
// Assumes two's-complement sample words.
package fmt_pkg;
    localparam int WORD_W  = 12;
    localparam int LANES   = 4;
    localparam int MID_W   = 10;
    localparam int LOW_W   = 8;

    typedef enum logic [1:0] {
        RND_FULL     = 2'd0,
        RND_MID      = 2'd1,
        RND_LOW      = 2'd2,
        RND_FULL_ALT = 2'd3
    } rnd_code_e;
endpackage

// File: rtl/sat_rounder.sv
// Module: sat_rounder
// Rounds a signed W-bit word to KEEP significant bits: adds half of the
// lowest kept bit, clears the dropped bits, and clamps a positive overflow
// to the largest positive value at that width. Purely combinational.
// Assumes KEEP < W.
module sat_rounder #(
    parameter int W    = 12,
    parameter int KEEP = 10
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int          DROP   = W - KEEP;
    localparam logic [W:0]  HALF   = (W+1)'(1) << (DROP - 1);
    localparam logic [W-1:0] LOWMSK = W'((1 << DROP) - 1);
    localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}} & ~LOWMSK;

    logic [W:0] sum;
    logic       ovf;

    // Sign-extend, add half an LSB, detect positive overflow.
    always_comb begin
        sum  = {din[W-1], din} + HALF;
        ovf  = !sum[W] && sum[W-1];
        dout = ovf ? MAXPOS : (sum[W-1:0] & ~LOWMSK);
    end
endmodule

// File: rtl/fmt_lane.sv
// Module: fmt_lane
// One output lane: picks the mixer or snapshot word, rounds it by round
// code, ANDs it with the lane mask and registers it with its enable flag.
// Assumes configuration fields are quasi-static; reset is synchronous,
// active low.
module fmt_lane
    import fmt_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int KEEP_M = MID_W,
    parameter int KEEP_L = LOW_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mix_word,
    input  logic [W-1:0] snap_word,
    input  logic         sel,
    input  logic [1:0]   mode,
    input  logic [W-1:0] mask,
    input  logic         en,
    output logic [W-1:0] y,
    output logic         oe
);
    localparam int DROP_M = W - KEEP_M;
    localparam int DROP_L = W - KEEP_L;

    logic [W-1:0] picked;
    logic [W-1:0] rnd_m;
    logic [W-1:0] rnd_l;
    logic [W-1:0] rounded;

    // Source choice between mixer and snapshot data.
    always_comb picked = sel ? snap_word : mix_word;

    sat_rounder #(.W(W), .KEEP(KEEP_M)) u_rnd_mid (.din(picked), .dout(rnd_m));
    sat_rounder #(.W(W), .KEEP(KEEP_L)) u_rnd_low (.din(picked), .dout(rnd_l));

    // Round-width selection by the lane's round code.
    always_comb begin
        unique case (rnd_code_e'(mode))
            RND_MID: rounded = rnd_m;
            RND_LOW: rounded = rnd_l;
            default: rounded = picked;
        endcase
    end

    // Output register: masked word when enabled, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y  <= '0;
            oe <= 1'b0;
        end else begin
            y  <= en ? (rounded & mask) : '0;
            oe <= en;
        end
    end

    // R9
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (y == '0 && !oe));
    // R9
    on_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> oe);
    // R8
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((y & ~$past(mask)) == '0));
    // R5
    mid_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'd1) |=> (y[DROP_M-1:0] == '0));
    // R6
    low_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'd2) |=> (y[DROP_L-1:0] == '0));
    // R7
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'd2 && picked == {1'b0, {(W-1){1'b1}}} && (&mask))
        |=> (y == ({1'b0, {(W-1){1'b1}}} & ~W'((1 << DROP_L) - 1))));
endmodule

// File: rtl/out_formatter.sv
// Module: out_formatter (top)
// Four independent formatting lanes. Lane k takes its mixer word or its
// snapshot word per src_sel[k], rounds by rnd_mode[2k+1:2k], masks by
// mask_word[12k+11:12k] and drives when lane_en[k] is set. One clock of
// latency. Assumes synchronous active-low reset.
module out_formatter
    import fmt_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = LANES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    mix_i_even,
    input  logic [W-1:0]    mix_q_even,
    input  logic [W-1:0]    mix_i_odd,
    input  logic [W-1:0]    mix_q_odd,
    input  logic [W-1:0]    snap_si,
    input  logic [W-1:0]    snap_sq,
    input  logic [W-1:0]    nco_cos,
    input  logic [W-1:0]    nco_sin,
    input  logic [N-1:0]    src_sel,
    input  logic [2*N-1:0]  rnd_mode,
    input  logic [W*N-1:0]  mask_word,
    input  logic [N-1:0]    lane_en,
    output logic [W-1:0]    lane_a,
    output logic [W-1:0]    lane_b,
    output logic [W-1:0]    lane_c,
    output logic [W-1:0]    lane_d,
    output logic [N-1:0]    lane_oe
);
    logic [W-1:0] mix_v  [N];
    logic [W-1:0] snap_v [N];
    logic [W-1:0] y_v    [N];

    // Fixed lane-to-source mapping (lane order A, B, C, D).
    always_comb begin
        mix_v[0]  = mix_i_even;
        mix_v[1]  = mix_q_even;
        mix_v[2]  = mix_i_odd;
        mix_v[3]  = mix_q_odd;
        snap_v[0] = snap_si;
        snap_v[1] = snap_sq;
        snap_v[2] = nco_cos;
        snap_v[3] = nco_sin;
    end

    for (genvar k = 0; k < N; k++) begin : g_lane
        fmt_lane #(.W(W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .mix_word  (mix_v[k]),
            .snap_word (snap_v[k]),
            .sel       (src_sel[k]),
            .mode      (rnd_mode[2*k +: 2]),
            .mask      (mask_word[W*k +: W]),
            .en        (lane_en[k]),
            .y         (y_v[k]),
            .oe        (lane_oe[k])
        );
    end

    // Unpack lane registers onto the named ports.
    always_comb begin
        lane_a = y_v[0];
        lane_b = y_v[1];
        lane_c = y_v[2];
        lane_d = y_v[3];
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (lane_oe == '0 && lane_a == '0 && lane_d == '0));
endmodule

// File: tb/tb_out_formatter.sv
// Scoreboard bench: the driver applies stimulus and pushes the expected
// lane values; the monitor pops and compares one clock later.
module tb_out_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mie, mqe, mio, mqo, ssi, ssq, ncos, nsin;
    logic [3:0]  src_sel;
    logic [7:0]  rnd_mode;
    logic [47:0] mask_word;
    logic [3:0]  lane_en;
    logic [11:0] lane_a, lane_b, lane_c, lane_d;
    logic [3:0]  lane_oe;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    typedef struct {
        int          due;
        logic [11:0] y [4];
        logic [3:0]  oe;
        string       tag;
    } exp_t;
    exp_t sb [$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    out_formatter dut (
        .clk(clk), .rst_n(rst_n),
        .mix_i_even(mie), .mix_q_even(mqe), .mix_i_odd(mio), .mix_q_odd(mqo),
        .snap_si(ssi), .snap_sq(ssq), .nco_cos(ncos), .nco_sin(nsin),
        .src_sel(src_sel), .rnd_mode(rnd_mode), .mask_word(mask_word),
        .lane_en(lane_en),
        .lane_a(lane_a), .lane_b(lane_b), .lane_c(lane_c), .lane_d(lane_d),
        .lane_oe(lane_oe)
    );

    // Reference rounding computed on signed integers.
    function automatic logic [11:0] ref_round(input logic [11:0] x, input logic [1:0] m);
        int v, step, r;
        v = $signed(x);
        step = (m == 2'd1) ? 4 : (m == 2'd2) ? 16 : 1;
        if (step == 1) return x;
        r = (v + step / 2) & ~(step - 1);
        if (r > 2047) r = 2048 - step;
        return r[11:0];
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply one stimulus at a falling edge and push the expectation.
    task automatic drive(input string tag,
                         input logic [11:0] m0, m1, m2, m3, s0, s1, s2, s3,
                         input logic [3:0] sel, input logic [7:0] md,
                         input logic [47:0] mk, input logic [3:0] en);
        exp_t e;
        logic [11:0] mv [4];
        logic [11:0] sv [4];
        @(negedge clk);
        mie = m0; mqe = m1; mio = m2; mqo = m3;
        ssi = s0; ssq = s1; ncos = s2; nsin = s3;
        src_sel = sel; rnd_mode = md; mask_word = mk; lane_en = en;
        mv = '{m0, m1, m2, m3};
        sv = '{s0, s1, s2, s3};
        for (int k = 0; k < 4; k++)
            e.y[k] = en[k] ? (ref_round(sel[k] ? sv[k] : mv[k], md[2*k +: 2]) & mk[12*k +: 12]) : 12'h000;
        e.oe  = en;
        e.due = cyc + 1;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare the front item once its clock has passed (R10 timing).
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " lane A"}, lane_a, e.y[0]);
            check({e.tag, " lane B"}, lane_b, e.y[1]);
            check({e.tag, " lane C"}, lane_c, e.y[2]);
            check({e.tag, " lane D"}, lane_d, e.y[3]);
            check({e.tag, " oe"}, {8'h0, lane_oe}, {8'h0, e.oe});
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0] ones;
        int seed;
        ones = {48{1'b1}};
        mie = 0; mqe = 0; mio = 0; mqo = 0; ssi = 0; ssq = 0; ncos = 0; nsin = 0;
        src_sel = 4'hF; rnd_mode = 0; mask_word = ones; lane_en = 4'hF;
        repeat (3) @(negedge clk);
        // R1: reset state, with enables already high
        check("R1 lane A", lane_a, 12'h000);
        check("R1 lane D", lane_d, 12'h000);
        check("R1 oe", {8'h0, lane_oe}, 12'h000);
        @(negedge clk) rst_n = 1'b1;

        drive("R2 mixer map", 12'h111, 12'h222, 12'h333, 12'h444,
              12'h555, 12'h666, 12'h777, 12'h888, 4'h0, 8'h00, ones, 4'hF);
        drive("R3 snapshot map", 12'h111, 12'h222, 12'h333, 12'h444,
              12'h555, 12'h666, 12'h777, 12'h888, 4'hF, 8'h00, ones, 4'hF);
        drive("R10 mixed select", 12'hA01, 12'hA02, 12'hA03, 12'hA04,
              12'h501, 12'h502, 12'h503, 12'h504, 4'b1010, 8'h00, ones, 4'hF);
        drive("R4 code 3 pass", 12'h7FF, 12'h801, 12'h003, 12'h00F,
              0, 0, 0, 0, 4'h0, 8'hFF, ones, 4'hF);
        drive("R5 round 10", 12'h123, 12'h122, 12'hFFE, 12'h801,
              0, 0, 0, 0, 4'h0, 8'h55, ones, 4'hF);
        drive("R6 round 8", 12'h128, 12'h127, 12'hFF8, 12'h801,
              0, 0, 0, 0, 4'h0, 8'hAA, ones, 4'hF);
        drive("R7 clamp", 12'h7FE, 12'h7FF, 12'h7F9, 12'h7F7,
              0, 0, 0, 0, 4'h0, 8'b10_10_01_01, ones, 4'hF);
        drive("R8 mask", 12'hFFF, 12'h123, 12'h7FE, 12'h0F0,
              0, 0, 0, 0, 4'h0, 8'b00_10_01_00, 48'h0F0_F0F_FFF_000, 4'hF);
        drive("R9 disable", 12'h321, 12'h654, 12'h987, 12'hCBA,
              12'h111, 12'h222, 12'h333, 12'h444, 4'b0110, 8'h00, ones, 4'b0101);
        drive("R9 all off", 12'h321, 12'h654, 12'h987, 12'hCBA,
              0, 0, 0, 0, 4'h0, 8'h00, ones, 4'h0);
        drive("R10 per-lane modes", 12'h00A, 12'h00A, 12'h00A, 12'h00A,
              12'h7FF, 12'h7FF, 12'h7FF, 12'h7FF, 4'b1100, 8'b11_10_01_00, ones, 4'hF);
        seed = 13;
        for (int i = 0; i < 200; i++) begin
            logic [11:0] w [8];
            for (int j = 0; j < 8; j++) begin
                seed = seed * 1103515245 + 12345;
                w[j] = seed[27:16];
            end
            drive("R10 sweep", w[0], w[1], w[2], w[3], w[4], w[5], w[6], w[7],
                  seed[3:0], seed[11:4], {w[3], w[2] | 12'hF00, w[1], ~w[0]},
                  seed[15:12] | 4'b0001);
        end
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R10: actual %0d pending expected 0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule